// File: doc/BRIEF.md
# System control register bank

This block is a bank of 32-bit control and status words that sits on a simple register bus inside a 4 KiB window. It holds the chip identity, a capture of the power-on strap pins, the cause of the last reset, a mask of disabled modules, lock bits, boot scratch words and a range of plain control words. Each word has one fixed access policy: read-only, write-one-to-clear, sticky write-one-to-set, or plain read/write. Software reaches the words with byte addresses. A word's index is the byte address divided by four.

The bus uses plain strobes. A cycle with `rd_en` high asks for a read. The data comes back on `rdata` with `rvalid` one clock later. A cycle with `wr_en` high writes `wdata`. The bus has no back-pressure: the bank accepts an access in every cycle and never stalls. Illegal accesses raise `err` for one cycle, in the same cycle in which read data would appear.

The cold reset loads a fixed table of values. Two words take their reset values from input ports instead: the strap capture word and the disabled-modules word. The warm reset clears only the bus response registers and leaves the storage alone.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst_cold_n` is low, the bank loads these reset values:
  - 0x04A92750 at 0x000, 0x0000FFFF at 0x014, 0x00000003 at 0x038, 0x0000035E at 0x03C and 0x0000004E at 0x050.
  - 0x80000000 at 0x06C, 0x000000C0 at 0x078, 0x5A00F3CF at 0x098 and 0x00001002 at 0x09C.
  - 0x00000008 at 0x13C, and 0x034730E4 at both 0x140 and 0x144.
  - Every other word resets to zero, apart from the two words named in R2.
  - `rvalid` and `err` are low during the reset.
- R2: The cold reset loads word 0x004 from `strap_in` and word 0x07C from `mod_off_in`.
- R3: A read returns `rdata` with `rvalid` high exactly one cycle after `rd_en`, and `rvalid` is low otherwise. A read and a write to the same word in the same cycle return the value from before the write.
- R4: Words 0x000, 0x004 and 0x040 are read-only. A write to one of them leaves it unchanged and raises `err` one cycle later.
- R5: Words 0x06C and 0x0D4 are write-one-to-clear: the new value is the old value AND NOT `wdata`.
- R6: Words 0x070 and 0x07C are sticky write-one-to-set: the new value is the old value OR `wdata`. No write ever clears a bit of these words.
- R7: All other words from 0x000 to 0x144 are read/write storage, including the boot scratch word at 0x13C. A written value reads back unchanged.
- R8: A read at or above byte address 0x148 returns zero and does not raise `err`. A write there changes nothing and raises `err` one cycle later.
- R9: An access with `addr[1:0]` not equal to zero, or with `be` not equal to 4'hF, raises `err` for exactly one cycle and changes no word. Such a read returns zero.
- R10: Driving `rst_warm_n` low leaves every word unchanged. The next cycle has `rvalid` and `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous cold reset, active low; loads all words |
| rst_warm_n | input | 1 | Synchronous warm reset, active low; clears only the bus response |
| strap_in | input | 32 | Reset value for the strap capture word (0x004) |
| mod_off_in | input | 32 | Reset value for the disabled-modules word (0x07C) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address inside the 4 KiB window |
| be | input | 4 | Byte enables; only 4'hF is legal |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| err | output | 1 | Illegal access, one cycle after the access |

## Verification
The hardest states to reach are the histories of the sticky and clearing words. Examples are a lock word built up over several writes, a clearing write aimed at a bit that is already zero, and a second cold reset that must restore both port-sourced words from new input values. The stimulus walks each of these words through a deliberate sequence of writes and reads. It then applies the cold reset a second time with different strap and mask values. It also issues a read and a write to the same word in one cycle, and a warm reset that lands on top of a read, to pin down those orderings.

// File: rtl/sysctl_regbank_pkg.sv
package sysctl_regbank_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned BE_W      = DATA_W / 8;
  localparam int unsigned NUM_WORDS = 82;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  localparam logic [DATA_W-1:0] CHIP_ID = 32'h04A9_2750;

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_W1C = 2'd2,
    ACC_W1S = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SRC_CONST  = 2'd0,
    SRC_STRAP  = 2'd1,
    SRC_MODOFF = 2'd2
  } src_e;

  // Word index -> access policy
  function automatic acc_e word_policy(int unsigned idx);
    case (idx)
      0, 1, 16: return ACC_RO;
      27, 53:   return ACC_W1C;
      28, 31:   return ACC_W1S;
      default:  return ACC_RW;
    endcase
  endfunction

  // Word index -> where the cold reset value comes from
  function automatic src_e word_source(int unsigned idx);
    case (idx)
      1:       return SRC_STRAP;
      31:      return SRC_MODOFF;
      default: return SRC_CONST;
    endcase
  endfunction

  // Word index -> constant cold reset value
  function automatic logic [DATA_W-1:0] word_reset(int unsigned idx);
    case (idx)
      0:       return CHIP_ID;
      5:       return 32'h0000_FFFF;
      14:      return 32'h0000_0003;
      15:      return 32'h0000_035E;
      20:      return 32'h0000_004E;
      27:      return 32'h8000_0000;
      30:      return 32'h0000_00C0;
      38:      return 32'h5A00_F3CF;
      39:      return 32'h0000_1002;
      79:      return 32'h0000_0008;
      80, 81:  return 32'h0347_30E4;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_regbank_pkg::*;
(
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic [IDX_W-1:0]  word_idx,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              err_next
);

  localparam int unsigned WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0] word_full;
  logic               shape_ok;
  logic               in_range;
  acc_e               pol;

  always_comb begin
    word_full = addr[ADDR_W-1:2];
    word_idx  = word_full[IDX_W-1:0];
    shape_ok  = (addr[1:0] == 2'b00) && (be == {BE_W{1'b1}});
    in_range  = (32'(word_full) < NUM_WORDS);
    pol       = word_policy(32'(word_full));
    rd_ok     = rd_en && shape_ok && in_range;
    wr_ok     = wr_en && shape_ok && in_range && (pol != ACC_RO);
    err_next  = (wr_en && !wr_ok) || (rd_en && !shape_ok);
  end

endmodule

// File: rtl/sysctl_word.sv
module sysctl_word
  import sysctl_regbank_pkg::*;
#(
  parameter acc_e              POLICY  = ACC_RW,
  parameter src_e              SRC     = SRC_CONST,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic [DATA_W-1:0] strap_val,
  input  logic [DATA_W-1:0] modoff_val,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] init_val;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (SRC)
      SRC_STRAP:  init_val = strap_val;
      SRC_MODOFF: init_val = modoff_val;
      default:    init_val = RST_VAL;
    endcase
    case (POLICY)
      ACC_RO:  nxt = q;
      ACC_W1C: nxt = q & ~wdata;
      ACC_W1S: nxt = q | wdata;
      default: nxt = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_cold_n) q <= init_val;
    else if (wr_hit) q <= nxt;
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              rst_warm_n,
  input  logic [DATA_W-1:0] strap_in,
  input  logic [DATA_W-1:0] mod_off_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);

  logic [IDX_W-1:0]  word_idx;
  logic              rd_ok;
  logic              wr_ok;
  logic              err_next;
  logic [DATA_W-1:0] words_q [NUM_WORDS];
  logic [DATA_W-1:0] rd_word;

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              err_q;

  sysctl_decode dec_i (
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .be       (be),
    .word_idx (word_idx),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .err_next (err_next)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam acc_e              W_POL = word_policy(i);
    localparam src_e              W_SRC = word_source(i);
    localparam logic [DATA_W-1:0] W_RST = word_reset(i);

    logic hit;
    assign hit = wr_ok && (word_idx == IDX_W'(i));

    sysctl_word #(
      .POLICY  (W_POL),
      .SRC     (W_SRC),
      .RST_VAL (W_RST)
    ) word_i (
      .clk        (clk),
      .rst_cold_n (rst_cold_n),
      .strap_val  (strap_in),
      .modoff_val (mod_off_in),
      .wr_hit     (hit),
      .wdata      (wdata),
      .q          (words_q[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (word_idx == IDX_W'(i)) rd_word = words_q[i];
    end
  end

  // Bus response stage: both resets clear it, only cold reset touches storage
  always_ff @(posedge clk) begin
    if (!rst_cold_n || !rst_warm_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      err_q    <= err_next;
      rdata_q  <= rd_ok ? rd_word : '0;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign err    = err_q;

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_cold_n,
  input logic              rst_warm_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BE_W-1:0]   be,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              err,
  input logic [DATA_W-1:0] lock_q,
  input logic [DATA_W-1:0] modoff_q
);

  logic past_ok;
  logic bad_shape;

  always_ff @(posedge clk) past_ok <= rst_cold_n;

  assign bad_shape = (addr[1:0] != 2'b00) || (be != 4'hF);

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    rd_en |=> rvalid);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    !rd_en |=> !rvalid);

  // R9
  bad_shape_err_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    ((rd_en || wr_en) && bad_shape) |=> err);

  // R8
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (rd_en && !wr_en && !bad_shape && (addr >= 12'h148)) |=> (rdata == '0 && !err));

  // R4
  chip_id_const_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (rd_en && !bad_shape && (addr == 12'h000)) |=> (rdata == CHIP_ID));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    past_ok |-> (($past(lock_q) & ~lock_q) == '0));

  // R6
  modoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    past_ok |-> (($past(modoff_q) & ~modoff_q) == '0));

  // R10
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    !rst_warm_n |=> (!rvalid && !err));

endmodule

bind sysctl_regbank sysctl_regbank_chk chk_i (
  .clk        (clk),
  .rst_cold_n (rst_cold_n),
  .rst_warm_n (rst_warm_n),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .be         (be),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .err        (err),
  .lock_q     (words_q[28]),
  .modoff_q   (words_q[31])
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_cold_n = 1'b0;
  logic        rst_warm_n = 1'b1;
  logic [31:0] strap_in = 32'hA5A5_0001;
  logic [31:0] mod_off_in = 32'h0000_0F00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        err;

  always #2 clk = ~clk;

  sysctl_regbank dut_i (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .rst_warm_n (rst_warm_n),
    .strap_in   (strap_in),
    .mod_off_in (mod_off_in),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .be         (be),
    .wdata      (wdata),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .err        (err)
  );

  typedef struct {
    int          due;
    logic        rv;
    logic [31:0] data;
    logic        er;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  // Scoreboard monitor: compares results one cycle after each access
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " rvalid"}, 32'(rvalid), 32'(e.rv));
      check({e.tag, " err"}, 32'(err), 32'(e.er));
      if (e.rv) check({e.tag, " rdata"}, rdata, e.data);
    end
  end

  // Driver: one bus cycle, expectation pushed to the scoreboard
  task automatic access(bit rd, bit wr, logic [11:0] a, logic [3:0] b,
                        logic [31:0] wd, logic [31:0] expd, bit experr, string tag);
    exp_t e;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; be = b; wdata = wd;
    e.due = cyc + 1; e.rv = rd; e.data = expd; e.er = experr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] expd, string tag);
    access(1'b1, 1'b0, a, 4'hF, '0, expd, 1'b0, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit experr, string tag);
    access(1'b0, 1'b1, a, 4'hF, d, '0, experr, tag);
  endtask

  task automatic idle(string tag);
    access(1'b0, 1'b0, '0, 4'hF, '0, '0, 1'b0, tag);
  endtask

  task automatic drain();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 reset rvalid", 32'(rvalid), 32'h0);
    check("R1 reset err", 32'(err), 32'h0);
    rst_cold_n = 1'b1;

    // R1 reset table
    rd(12'h000, 32'h04A9_2750, "R1 id");
    rd(12'h014, 32'h0000_FFFF, "R1 w014");
    rd(12'h038, 32'h0000_0003, "R1 w038");
    rd(12'h03C, 32'h0000_035E, "R1 w03C");
    rd(12'h050, 32'h0000_004E, "R1 w050");
    rd(12'h06C, 32'h8000_0000, "R1 w06C");
    rd(12'h078, 32'h0000_00C0, "R1 w078");
    rd(12'h098, 32'h5A00_F3CF, "R1 w098");
    rd(12'h09C, 32'h0000_1002, "R1 w09C");
    rd(12'h13C, 32'h0000_0008, "R1 w13C");
    rd(12'h140, 32'h0347_30E4, "R1 w140");
    rd(12'h144, 32'h0347_30E4, "R1 w144");
    rd(12'h00C, 32'h0, "R1 w00C");
    rd(12'h040, 32'h0, "R1 w040");
    rd(12'h070, 32'h0, "R1 w070");
    // R2 port-sourced words
    rd(12'h004, 32'hA5A5_0001, "R2 strap");
    rd(12'h07C, 32'h0000_0F00, "R2 modoff");

    // R7 plain storage
    wr(12'h13C, 32'hDEAD_BEEF, 1'b0, "R7 wr scratch");
    rd(12'h13C, 32'hDEAD_BEEF, "R7 scratch");
    wr(12'h080, 32'h1234_5678, 1'b0, "R7 wr 080");
    wr(12'h0B0, 32'h0F0F_A5A5, 1'b0, "R7 wr 0B0");
    rd(12'h080, 32'h1234_5678, "R7 080");
    rd(12'h0B0, 32'h0F0F_A5A5, "R7 0B0");

    // R3 same-cycle read and write
    access(1'b1, 1'b1, 12'h084, 4'hF, 32'hCAFE_F00D, 32'h0, 1'b0, "R3 rd+wr old");
    rd(12'h084, 32'hCAFE_F00D, "R3 after");

    // R4 read-only words
    wr(12'h000, 32'h0, 1'b1, "R4 wr id");
    rd(12'h000, 32'h04A9_2750, "R4 id kept");
    wr(12'h004, 32'hFFFF_FFFF, 1'b1, "R4 wr strap");
    rd(12'h004, 32'hA5A5_0001, "R4 strap kept");
    wr(12'h040, 32'hFFFF_FFFF, 1'b1, "R4 wr 040");
    rd(12'h040, 32'h0, "R4 040 kept");

    // R5 write-one-to-clear
    wr(12'h06C, 32'h0000_0001, 1'b0, "R5 wr clear unset");
    rd(12'h06C, 32'h8000_0000, "R5 unchanged");
    wr(12'h06C, 32'h8000_0000, 1'b0, "R5 wr clear");
    rd(12'h06C, 32'h0, "R5 cleared");
    wr(12'h0D4, 32'hFFFF_FFFF, 1'b0, "R5 wr 0D4");
    rd(12'h0D4, 32'h0, "R5 0D4 stays");

    // R6 sticky set
    wr(12'h070, 32'h0000_00F0, 1'b0, "R6 wr lock a");
    wr(12'h070, 32'h0000_0F00, 1'b0, "R6 wr lock b");
    wr(12'h070, 32'h0, 1'b0, "R6 wr lock zero");
    rd(12'h070, 32'h0000_0FF0, "R6 lock");
    wr(12'h07C, 32'h0000_0001, 1'b0, "R6 wr modoff");
    rd(12'h07C, 32'h0000_0F01, "R6 modoff");

    // R8 beyond the storage
    rd(12'h148, 32'h0, "R8 rd 148");
    rd(12'hFFC, 32'h0, "R8 rd FFC");
    wr(12'h148, 32'hFFFF_FFFF, 1'b1, "R8 wr 148");
    rd(12'h148, 32'h0, "R8 rd 148 again");
    rd(12'h144, 32'h0347_30E4, "R8 144 kept");

    // R9 partial and misaligned
    access(1'b0, 1'b1, 12'h13C, 4'b0011, 32'h0, 32'h0, 1'b1, "R9 partial wr");
    rd(12'h13C, 32'hDEAD_BEEF, "R9 partial kept");
    access(1'b0, 1'b1, 12'h13D, 4'hF, 32'h0, 32'h0, 1'b1, "R9 misaligned wr");
    rd(12'h13C, 32'hDEAD_BEEF, "R9 misaligned kept");
    access(1'b1, 1'b0, 12'h002, 4'hF, 32'h0, 32'h0, 1'b1, "R9 misaligned rd");
    idle("R9 err one cycle");

    // R10 warm reset on top of a read
    @(negedge clk);
    rst_warm_n = 1'b0; rd_en = 1'b1; wr_en = 1'b0; addr = 12'h13C;
    begin
      exp_t e;
      e.due = cyc + 1; e.rv = 1'b0; e.data = '0; e.er = 1'b0; e.tag = "R10 warm quiet";
      exp_q.push_back(e);
    end
    @(negedge clk);
    rst_warm_n = 1'b1; rd_en = 1'b0;
    rd(12'h13C, 32'hDEAD_BEEF, "R10 scratch kept");
    rd(12'h070, 32'h0000_0FF0, "R10 lock kept");
    rd(12'h080, 32'h1234_5678, "R10 080 kept");
    drain();

    // R1 and R2 under a second cold reset with new inputs
    strap_in = 32'h1234_5678; mod_off_in = 32'h0000_0003;
    rst_cold_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_cold_n = 1'b1;
    rd(12'h004, 32'h1234_5678, "R2 strap again");
    rd(12'h07C, 32'h0000_0003, "R2 modoff again");
    rd(12'h070, 32'h0, "R1 lock cleared");
    rd(12'h13C, 32'h0000_0008, "R1 scratch reset");
    rd(12'h06C, 32'h8000_0000, "R1 cause reset");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule